// File: doc/BRIEF.md
# Frame Preemption Verify Handshake Controller

This block runs the verify handshake of a transmitter that supports frame preemption. Before preemptible traffic may be split into fragments, the transmitter asks for a verify frame, waits a programmable number of wire-side clocks for the link partner's response, and then decides whether the partner supports preemption. Frame construction, CRC and receive classification are handled elsewhere. This block only issues a one-cycle request for a verify frame and consumes two classified receive strobes: a valid response and an erroneous verify/response frame.

Software controls the handshake with three inputs. A link-fail bit holds the machine in its idle state and clears every status bit. A 1-to-0 transition of that bit starts a fresh attempt. A disable-verify bit skips the handshake entirely. The timeout is supplied as a count of wire-side clocks. A typical value is 0x1312D0, which is 10 ms at 125 MHz. Status comes out as four separate bits. An 8-bit preemptible traffic-class mask passes to the output only once the link has been verified or verification is disabled.

States: RESET (idle, held while link-fail or disable-verify is high), SEND (one cycle, request asserted, timer loaded), WAIT (counting down), VERIFIED and FAILED (terminal until link-fail). Transitions:
- RESET→SEND on a link-fail falling edge with verify enabled.
- SEND→WAIT always.
- WAIT→VERIFIED on a response.
- WAIT→FAILED on an error strobe.
- WAIT→SEND on a timeout with retries left.
- WAIT→FAILED on a timeout after the last try.
- Any state→RESET while link-fail or disable-verify is high.

Top module: `pmac_verify_fsm`

## Requirements
- R1: After reset, every output is 0 and no request is issued.
- R2: While `link_fail_i` is 1, the next cycle shows no request, `verified_o` is 0, and all three sticky status bits (`verify_fail_o`, `resp_err_o`, `verify_err_o`) are 0.
- R3: A 1-to-0 transition of `link_fail_i`, seen at a clock edge while `verify_off_i` is 0, makes `verify_req_o` high for exactly one cycle after that edge. Without such a transition, no request is ever issued.
- R4: After each request, the block waits exactly T cycles, where T is `timeout_i` captured in the request cycle, and a value of 0 is treated as 1. If no strobe arrives, it issues the next request, so consecutive requests are T+1 cycles apart.
- R5: A `resp_rx_i` pulse during the wait makes `verified_o` 1 from the next cycle. It stays 1 until `link_fail_i` or `verify_off_i` rises.
- R6: After MAX_TRIES (default 3) requests that all time out, `verify_fail_o` becomes 1 and no further request is issued.
- R7: A `resp_rx_i` pulse at any time other than the wait, while `link_fail_i` is 0, sets the sticky `resp_err_o`. It does not change `verified_o`.
- R8: An `err_rx_i` pulse during the wait sets `verify_err_o` and ends the attempt with no further request. An `err_rx_i` pulse outside the wait has no effect.
- R9: `pmask_o` equals `pmask_i` while `verified_o` is 1, and is all zeros while neither `verified_o` nor `verify_off_i` is 1.
- R10: While `verify_off_i` is 1, no request is issued and `pmask_o` equals `pmask_i` in the same cycle. Clearing `verify_off_i` does not start an attempt.
- R11: If `resp_rx_i` and `err_rx_i` arrive in the same wait cycle, the response wins: the result is verified, and `verify_err_o` stays 0.
- R12: Raising `link_fail_i` during the wait aborts the attempt. No further request follows while it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_fail_i | input | 1 | Hold-in-idle control; its falling edge starts verification |
| verify_off_i | input | 1 | Skip verification; mask applies at once |
| timeout_i | input | CNT_W | Wait length in clocks per attempt |
| resp_rx_i | input | 1 | A valid response frame was received |
| err_rx_i | input | 1 | An erroneous verify/response frame was received |
| pmask_i | input | TC_NUM | Requested preemptible class mask |
| verify_req_o | output | 1 | One-cycle request to transmit a verify frame |
| verified_o | output | 1 | Partner verified |
| verify_fail_o | output | 1 | All tries timed out |
| resp_err_o | output | 1 | Response arrived while none was awaited |
| verify_err_o | output | 1 | Error strobe ended the wait |
| pmask_o | output | TC_NUM | Effective preemptible class mask |

## Verification
The bench checks several corner cases that a faulty design would get wrong.
- Request spacing with a zero timeout: a design that skips the 0-to-1 promotion would stall or wrap the counter, and the two-cycle spacing would be lost.
- Last-try boundary: an off-by-one retry count would show a fourth request or report failure one attempt early.
- Response arriving after the verdict: a design that did not track the wait window would either miss the respond error or drop the verified state.
- Simultaneous response and error: a design with the wrong priority would report a verify error.
- Stray error outside the wait, mid-wait abort by link-fail, and clearing disable-verify: each must leave the outputs quiet, and a design that starts on level instead of edge would issue unexpected requests.

// File: rtl/pmac_verify_pkg.sv
package pmac_verify_pkg;

    typedef enum logic [2:0] {
        VS_RESET    = 3'd0,
        VS_SEND     = 3'd1,
        VS_WAIT     = 3'd2,
        VS_VERIFIED = 3'd3,
        VS_FAILED   = 3'd4
    } vfy_state_e;

    typedef struct packed {
        logic fail;
        logic rerr;
        logic verr;
    } vfy_flags_t;

endpackage

// File: rtl/pmac_vfy_timer.sv
module pmac_vfy_timer #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] init_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // A count of 0 or 1 means the current cycle is the last one of the wait
    assign expire_o = (cnt_q[CNT_W-1:1] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= init_i;
        end else if (run_i && !expire_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pmac_vfy_flags.sv
module pmac_vfy_flags
    import pmac_verify_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  vfy_flags_t set_i,
    output vfy_flags_t flags_o
);

    vfy_flags_t flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clr_i) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | set_i;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/pmac_vfy_mask.sv
module pmac_vfy_mask #(
    parameter int TC_NUM = 8
) (
    input  logic              open_i,
    input  logic [TC_NUM-1:0] mask_i,
    output logic [TC_NUM-1:0] mask_o
);

    for (genvar b = 0; b < TC_NUM; b++) begin : g_bit
        assign mask_o[b] = mask_i[b] & open_i;
    end

endmodule

// File: rtl/pmac_verify_fsm.sv
module pmac_verify_fsm
    import pmac_verify_pkg::*;
#(
    parameter int CNT_W     = 21,
    parameter int MAX_TRIES = 3,
    parameter int TC_NUM    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_fail_i,
    input  logic              verify_off_i,
    input  logic [CNT_W-1:0]  timeout_i,
    input  logic              resp_rx_i,
    input  logic              err_rx_i,
    input  logic [TC_NUM-1:0] pmask_i,
    output logic              verify_req_o,
    output logic              verified_o,
    output logic              verify_fail_o,
    output logic              resp_err_o,
    output logic              verify_err_o,
    output logic [TC_NUM-1:0] pmask_o
);

    localparam int              TRY_W    = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES);

    vfy_state_e       st_q, st_d;
    logic             lf_q;
    logic [TRY_W-1:0] tries_q;
    logic             expire;
    logic             awaiting;
    logic             start;
    vfy_flags_t       flag_set, flag_q;

    assign awaiting = (st_q == VS_WAIT) && !verify_off_i;
    assign start    = lf_q && !link_fail_i && !verify_off_i;

    // Next-state decision
    always_comb begin
        st_d = st_q;
        if (link_fail_i || verify_off_i) begin
            st_d = VS_RESET;
        end else begin
            unique case (st_q)
                VS_RESET:    if (start) st_d = VS_SEND;
                VS_SEND:     st_d = VS_WAIT;
                VS_WAIT: begin
                    if (resp_rx_i)      st_d = VS_VERIFIED;
                    else if (err_rx_i)  st_d = VS_FAILED;
                    else if (expire)    st_d = (tries_q == TRY_LAST) ? VS_FAILED : VS_SEND;
                end
                VS_VERIFIED: st_d = VS_VERIFIED;
                VS_FAILED:   st_d = VS_FAILED;
                default:     st_d = VS_RESET;
            endcase
        end
    end

    // State register, link-fail history and try counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= VS_RESET;
            lf_q    <= 1'b0;
            tries_q <= '0;
        end else begin
            st_q <= st_d;
            lf_q <= link_fail_i;
            if (st_q == VS_RESET)     tries_q <= '0;
            else if (st_q == VS_SEND) tries_q <= tries_q + 1'b1;
        end
    end

    // Sticky status set conditions
    always_comb begin
        flag_set.fail = awaiting && !resp_rx_i && !err_rx_i && expire && (tries_q == TRY_LAST);
        flag_set.verr = awaiting && !resp_rx_i && err_rx_i;
        flag_set.rerr = resp_rx_i && !awaiting;
    end

    pmac_vfy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (st_q == VS_SEND),
        .run_i    (awaiting),
        .init_i   (timeout_i),
        .expire_o (expire)
    );

    pmac_vfy_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (link_fail_i),
        .set_i   (flag_set),
        .flags_o (flag_q)
    );

    pmac_vfy_mask #(.TC_NUM(TC_NUM)) u_mask (
        .open_i (verify_off_i || (st_q == VS_VERIFIED)),
        .mask_i (pmask_i),
        .mask_o (pmask_o)
    );

    // Outputs
    always_comb begin
        verify_req_o  = (st_q == VS_SEND);
        verified_o    = (st_q == VS_VERIFIED);
        verify_fail_o = flag_q.fail;
        resp_err_o    = flag_q.rerr;
        verify_err_o  = flag_q.verr;
    end

endmodule

// File: rtl/pmac_verify_chk.sv
module pmac_verify_chk #(
    parameter int TC_NUM = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_fail_i,
    input logic              verify_off_i,
    input logic [TC_NUM-1:0] pmask_i,
    input logic              verify_req_o,
    input logic              verified_o,
    input logic              verify_fail_o,
    input logic              resp_err_o,
    input logic              verify_err_o,
    input logic [TC_NUM-1:0] pmask_o
);

    // R2
    link_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_i |=> (!verify_req_o && !verified_o && !verify_fail_o && !resp_err_o && !verify_err_o));

    // R3
    req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(link_fail_i) && !verify_off_i) |=> verify_req_o);

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req_o |=> !verify_req_o);

    // R5
    verified_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verified_o && !link_fail_i && !verify_off_i) |=> verified_o);

    // R6
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_fail_o |-> !verify_req_o);

    // R7
    rerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_err_o && !link_fail_i) |=> resp_err_o);

    // R8
    verr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_err_o |-> (!verify_req_o && !verified_o));

    // R9
    mask_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verified_o |-> (pmask_o == pmask_i));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_off_i |=> !verify_req_o);

endmodule

bind pmac_verify_fsm pmac_verify_chk #(.TC_NUM(TC_NUM)) u_chk (.*);

// File: tb/pmac_verify_fsm_tb_top.sv
`timescale 1ns/1ps
module pmac_verify_fsm_tb_top;

    localparam int CNT_W = 21;
    localparam int TRIES = 3;
    localparam int TCN   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            link_fail = 1'b0;
    logic            voff = 1'b0;
    logic [CNT_W-1:0] tmo = 21'd5;
    logic            resp = 1'b0;
    logic            err = 1'b0;
    logic [TCN-1:0]  pm_in = 8'hA5;
    logic            req, ver, vfail, rerr, verr;
    logic [TCN-1:0]  pm_out;

    always #10 clk = ~clk;

    pmac_verify_fsm #(.CNT_W(CNT_W), .MAX_TRIES(TRIES), .TC_NUM(TCN)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_fail_i(link_fail), .verify_off_i(voff),
        .timeout_i(tmo), .resp_rx_i(resp), .err_rx_i(err), .pmask_i(pm_in),
        .verify_req_o(req), .verified_o(ver), .verify_fail_o(vfail),
        .resp_err_o(rerr), .verify_err_o(verr), .pmask_o(pm_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 request, 2 waiting, 3 verified, 4 failed
    int m_mode, m_left, m_sent;
    bit m_fail, m_verr, m_rerr, m_lfp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_sent = 0;
            m_fail = 0; m_verr = 0; m_rerr = 0; m_lfp = 0;
        end else begin
            bit waiting;
            waiting = (m_mode == 2) && !voff;
            if (link_fail) begin
                m_mode = 0; m_fail = 0; m_verr = 0; m_rerr = 0;
            end else begin
                if (resp && !waiting) m_rerr = 1;
                if (voff) m_mode = 0;
                else if (m_mode == 0) begin
                    if (m_lfp) begin m_mode = 1; m_sent = 0; end
                end else if (m_mode == 1) begin
                    m_mode = 2;
                    m_left = (tmo == 0) ? 1 : int'(tmo);
                    m_sent++;
                end else if (m_mode == 2) begin
                    if (resp) m_mode = 3;
                    else if (err) begin m_mode = 4; m_verr = 1; end
                    else if (m_left <= 1) begin
                        if (m_sent >= TRIES) begin m_mode = 4; m_fail = 1; end
                        else m_mode = 1;
                    end else m_left--;
                end
            end
            m_lfp = link_fail;
        end
    end

    // Per-clock comparison and request monitor
    int n_req = 0;
    int last_req = -1;
    int gap = 0;
    int cyc_n = 0;

    always @(negedge clk) begin
        cyc_n++;
        if (rst_n && !finished) begin
            chk(req == (m_mode == 1), "R3/R4 verify_req_o", req, m_mode == 1);
            chk(ver == (m_mode == 3), "R5 verified_o", ver, m_mode == 3);
            chk(vfail == m_fail, "R6 verify_fail_o", vfail, m_fail);
            chk(rerr == m_rerr, "R7 resp_err_o", rerr, m_rerr);
            chk(verr == m_verr, "R8 verify_err_o", verr, m_verr);
            chk(pm_out == ((voff || m_mode == 3) ? pm_in : '0), "R9/R10 pmask_o",
                pm_out, (voff || m_mode == 3) ? pm_in : 0);
            if (req) begin
                if (last_req >= 0) gap = cyc_n - last_req;
                last_req = cyc_n;
                n_req++;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic clear_mon();
        n_req = 0; last_req = -1; gap = 0;
    endtask

    task automatic restart();
        link_fail = 1'b1; cyc(2); clear_mon(); link_fail = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk({req, ver, vfail, rerr, verr} == 5'b0, "R1 outputs after reset", {req, ver, vfail, rerr, verr}, 0);
        chk(pm_out == 0, "R1 mask after reset", pm_out, 0);

        // R3 no falling edge, no request
        clear_mon(); cyc(10);
        chk(n_req == 0, "R3 no start without edge", n_req, 0);

        // R5/R9 response inside wait
        restart(); cyc(3);
        resp = 1'b1; cyc(1); resp = 1'b0; cyc(1);
        chk(ver == 1, "R5 verified", ver, 1);
        chk(pm_out == 8'hA5, "R9 mask open", pm_out, 8'hA5);
        chk(n_req == 1, "R3 single request", n_req, 1);

        // R7 response after verdict
        resp = 1'b1; cyc(1); resp = 1'b0; cyc(1);
        chk(rerr == 1, "R7 resp_err set", rerr, 1);
        chk(ver == 1, "R7 verified kept", ver, 1);

        // R8 error outside wait ignored
        err = 1'b1; cyc(1); err = 1'b0; cyc(1);
        chk(verr == 0, "R8 stray error ignored", verr, 0);

        // R2 link fail clears status
        link_fail = 1'b1; cyc(2);
        chk({ver, vfail, rerr, verr} == 4'b0, "R2 status cleared", {ver, vfail, rerr, verr}, 0);

        // R4/R6 all tries time out
        tmo = 21'd4; restart(); cyc(25);
        chk(n_req == TRIES, "R6 request count", n_req, TRIES);
        chk(gap == 5, "R4 request spacing", gap, 5);
        chk(vfail == 1, "R6 verify_fail", vfail, 1);

        // R8 error inside wait
        tmo = 21'd6; restart(); cyc(3);
        err = 1'b1; cyc(1); err = 1'b0; cyc(10);
        chk(verr == 1, "R8 verify_err", verr, 1);
        chk(n_req == 1, "R8 no retry after error", n_req, 1);
        chk(ver == 0 && vfail == 0, "R8 no other verdict", {ver, vfail}, 0);

        // R11 both strobes in one wait cycle
        restart(); cyc(4);
        resp = 1'b1; err = 1'b1; cyc(1); resp = 1'b0; err = 1'b0; cyc(1);
        chk(ver == 1, "R11 response wins", ver, 1);
        chk(verr == 0, "R11 no verify_err", verr, 0);

        // R4 zero timeout behaves as one
        tmo = 21'd0; restart(); cyc(12);
        chk(gap == 2, "R4 zero timeout spacing", gap, 2);
        chk(n_req == TRIES, "R4 zero timeout tries", n_req, TRIES);

        // R12 abort mid-wait
        tmo = 21'd20; restart(); cyc(4);
        link_fail = 1'b1; cyc(40);
        chk(n_req == 1, "R12 aborted", n_req, 1);
        chk(vfail == 0, "R12 no failure", vfail, 0);

        // R10 verification disabled
        pm_in = 8'h3C; voff = 1'b1; cyc(1);
        chk(pm_out == 8'h3C, "R10 mask immediate", pm_out, 8'h3C);
        clear_mon(); link_fail = 1'b0; cyc(30);
        chk(n_req == 0, "R10 no request", n_req, 0);
        voff = 1'b0; cyc(5);
        chk(n_req == 0, "R10 no start on clear", n_req, 0);
        chk(pm_out == 0, "R9 mask closed", pm_out, 0);

        cyc(2);
        summary();
    end

endmodule